// File: doc/BRIEF.md
# Cascadable synchronous presettable counter

This block is a small up counter whose every state change happens on the rising clock edge. A synchronous active-low clear forces the count to zero. A synchronous active-low load copies a data word into the count. Two enables must both be high for the count to advance by one. When neither clear nor load is active and either enable is low, the count holds. Clear and load act whatever the enables are, and clear wins when both are asserted at the same edge.

The block drives a carry output that is high while the count sits at its top value and the trailing enable is high. The carry ignores the leading enable. To build a wider synchronous counter, each stage's carry drives the next stage's trailing enable, and the leading enable goes to all stages in parallel. No extra gating is needed. Driving the clear input from a decode of the count shortens the counting cycle. The stage width is a parameter with a default of 4 bits.

Top module: `sync_preset_counter`

## Requirements
- R1: The count output changes only at a rising clock edge. Changing clr_n, ld_n, din, en_p or en_t between edges leaves q unchanged.
- R2: When clr_n is 0 at a rising edge, q becomes 0 after that edge, for every level of en_p and en_t.
- R3: When clr_n is 1 and ld_n is 0 at a rising edge, q takes din after that edge, for every level of en_p and en_t. Any value from 0 to 15 can be loaded.
- R4: When clr_n and ld_n are both 0 at the same edge, clear has priority and q becomes 0.
- R5: When clr_n and ld_n are both 1 and en_p and en_t are both 1, q increments by one at the edge, wrapping from 15 to 0.
- R6: When clr_n and ld_n are both 1 and en_p or en_t is 0, q holds its value across the edge.
- R7: carry is 1 exactly when q equals 15 and en_t is 1, whatever en_p is. carry responds in the same cycle, with no register on its path.
- R8: Three stages are chained. Each stage's carry feeds the next stage's en_t, and the stages share en_p, clr_n and ld_n. The combined 12-bit value then advances by one per enabled clock, wraps from 4095 to 0, and loads and clears as one 12-bit counter.
- R9: Driving clr_n from a decode of count value N makes the count cycle through 0 to N and repeat, a period of N+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous load of din, active low |
| din | input | W | Preset data |
| en_p | input | 1 | Count enable that does not gate the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| q | output | W | Current count |
| carry | output | 1 | High while q is all ones and en_t is high |

## Verification
The whole state is the count register, so any wrong state appears on q right after the edge that produced it. The same value shows on carry in that cycle when it involves the top count. The bench loads every count value, applies every clear, load and enable combination, and checks q one edge later. It sweeps carry over every count and enable level. A fault in the increment or wrap path shows most clearly in the three-stage chain, because there the low stage's wrap must produce exactly one step in the stage above it.

// File: rtl/sync_preset_counter.sv
module sync_preset_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic [W-1:0] din,
  input  logic         en_p,
  input  logic         en_t,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt;
  logic         run;

  assign run = en_p & en_t;

  always_ff @(posedge clk) begin
    if (!clr_n)     cnt <= '0;
    else if (!ld_n) cnt <= din;
    else if (run)   cnt <= cnt + 1'b1;
  end

  assign q     = cnt;
  assign carry = en_t & (cnt == TOP);

  // checker qualifier: state is defined once a clear has been taken
  logic known;
  always_ff @(posedge clk) known <= known | !clr_n;

  p_clear_r2: assert property (@(posedge clk) disable iff (!known)
    !clr_n |=> q == '0);
  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!known)
    (!clr_n && !ld_n) |=> q == '0);
  p_load_r3: assert property (@(posedge clk) disable iff (!known)
    (clr_n && !ld_n) |=> q == $past(din));
  p_count_r5: assert property (@(posedge clk) disable iff (!known)
    (clr_n && ld_n && en_p && en_t) |=> q == $past(q) + 1'b1);
  p_hold_r6: assert property (@(posedge clk) disable iff (!known)
    (clr_n && ld_n && !(en_p && en_t)) |=> $stable(q));
  p_carry_gate_r7: assert property (@(posedge clk) disable iff (!known)
    !en_t |-> !carry);
  p_carry_wrap_r8: assert property (@(posedge clk) disable iff (!known)
    (carry && en_p && clr_n && ld_n) |=> q == '0);
endmodule

// File: tb/sync_preset_counter_test.sv
`timescale 1ns/1ps
module sync_preset_counter_test;
  logic clk = 0;
  always #2.5 clk = ~clk;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  logic       clr_r = 1, ld_n = 1, en_p = 0, en_t = 0, mod_mode = 0;
  logic [3:0] din = 0;
  logic [3:0] q;
  logic       carry, clr_w;

  assign clr_w = mod_mode ? (q != 4'd9) : clr_r;

  sync_preset_counter #(.W(4)) uut (
    .clk(clk), .clr_n(clr_w), .ld_n(ld_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q), .carry(carry));

  logic        c_clr = 1, c_ld = 1, c_enp = 0, c_ent = 0;
  logic [11:0] c_din = 0;
  logic [3:0]  cq0, cq1, cq2;
  logic        cc0, cc1, cc2;
  logic [11:0] cval;
  assign cval = {cq2, cq1, cq0};

  sync_preset_counter #(.W(4)) st0 (.clk(clk), .clr_n(c_clr), .ld_n(c_ld),
    .din(c_din[3:0]), .en_p(c_enp), .en_t(c_ent), .q(cq0), .carry(cc0));
  sync_preset_counter #(.W(4)) st1 (.clk(clk), .clr_n(c_clr), .ld_n(c_ld),
    .din(c_din[7:4]), .en_p(c_enp), .en_t(cc0), .q(cq1), .carry(cc1));
  sync_preset_counter #(.W(4)) st2 (.clk(clk), .clr_n(c_clr), .ld_n(c_ld),
    .din(c_din[11:8]), .en_p(c_enp), .en_t(cc1), .q(cq2), .carry(cc2));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [3:0] exp, hold;
    logic [11:0] ref12;
    #1;
    // reset state through synchronous clear
    clr_r = 0; step(); clr_r = 1;
    check(q == 0, "R2 reset", q, 0);

    // exhaustive single-stage sweep: every start value and control combination
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 16; m++) begin
        ld_n = 0; din = 4'(s); clr_r = 1; en_p = 0; en_t = 0; step();
        clr_r = m[3]; ld_n = m[2]; en_p = m[1]; en_t = m[0];
        din = ~4'(s);
        if (!clr_r)                exp = 0;
        else if (!ld_n)            exp = ~4'(s);
        else if (en_p && en_t)     exp = 4'((s + 1) % 16);
        else                       exp = 4'(s);
        step();
        if (!clr_r && !ld_n)       check(q == exp, "R4 clear over load", q, exp);
        else if (!clr_r)           check(q == exp, "R2 clear", q, exp);
        else if (!ld_n)            check(q == exp, "R3 load", q, exp);
        else if (en_p && en_t)     check(q == exp, "R5 count", q, exp);
        else                       check(q == exp, "R6 hold", q, exp);
      end
    end
    clr_r = 1; ld_n = 1;

    // R1: input changes between edges leave q alone
    ld_n = 0; din = 4'd6; step(); ld_n = 1;
    hold = q;
    @(negedge clk);
    clr_r = 0; ld_n = 0; din = 4'd13; en_p = 1; en_t = 1; #1;
    check(q == hold, "R1 no change between edges", q, hold);
    clr_r = 1; ld_n = 1; en_p = 0; #1;
    check(q == hold, "R1 no change between edges", q, hold);

    // R7: carry sweep over every count and enable level
    for (int s = 0; s < 16; s++) begin
      ld_n = 0; din = 4'(s); en_p = 0; en_t = 0; step(); ld_n = 1;
      for (int e = 0; e < 4; e++) begin
        en_p = e[1]; en_t = e[0]; #1;
        check(carry == ((s == 15) && e[0]), "R7 carry", carry, (s == 15) && e[0]);
      end
      en_p = 0; en_t = 0;
    end

    // R9: decode-driven clear gives a period of 10
    clr_r = 0; step(); clr_r = 1;
    mod_mode = 1; en_p = 1; en_t = 1;
    for (int k = 1; k <= 30; k++) begin
      step();
      check(q == 4'(k % 10), "R9 modulo", q, k % 10);
    end
    mod_mode = 0; en_p = 0; en_t = 0;

    // R8: three-stage chain, step and wrap
    c_ld = 0; c_din = 12'd4090; step(); c_ld = 1;
    check(cval == 12'd4090, "R8 chain load", cval, 4090);
    c_enp = 1; c_ent = 1;
    for (int k = 1; k <= 10; k++) begin
      step();
      check(cval == 12'((4090 + k) % 4096), "R8 chain wrap", cval, (4090 + k) % 4096);
    end
    c_ld = 0; c_din = 12'h0FF; step(); c_ld = 1;
    step();
    check(cval == 12'h100, "R8 chain carry into stage 2", cval, 12'h100);

    // R8: random activity against a 12-bit reference
    c_clr = 0; step(); c_clr = 1; ref12 = 0;
    for (int k = 0; k < 3000; k++) begin
      c_clr = ($urandom_range(19) != 0);
      c_ld  = ($urandom_range(19) != 0);
      c_enp = ($urandom_range(3) != 0);
      c_ent = ($urandom_range(3) != 0);
      c_din = 12'($urandom);
      if (!c_clr)               ref12 = 0;
      else if (!c_ld)           ref12 = c_din;
      else if (c_enp && c_ent)  ref12 = ref12 + 1'b1;
      step();
      check(cval == ref12, "R8 chain random", cval, ref12);
    end

    finish_run();
  end
endmodule